// File: doc/BRIEF.md
# Password-Gated Clock Control Register File

This block is the register front end of a clock controller. A simple single-cycle bus (valid, write, byte address, write data) reaches a 32-bit register window of 8 KiB. Behind it sit one control register per PLL and one control register per PLL output channel. Each register's contents drive the PLL and divider logic outside the block, and a one-cycle update strobe tells each unit when to reload. The frequency arithmetic itself lives elsewhere.

Every write must carry a fixed key in its top byte. A write without the key is thrown away. A write with the key is stored with the key byte forced to zero. A PLL control register also governs that PLL's channels, so writing it pulses the strobe of the PLL and of all its channels. One address holds no storage. It returns a lock-status word built at read time from the live lock inputs of the PLLs.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset all stored registers, all update strobes and the read data are zero.
- R2: A write whose bits 31:24 differ from 0x5A is dropped: no register changes and no strobe pulses.
- R3: An accepted write stores bits 23:0 of the data with bits 31:24 cleared, and reads of that register return the stored word.
- R4: Only word-aligned accesses act (byte address bits 1:0 equal to zero); a misaligned write changes nothing and a misaligned read returns zero.
- R5: The word index is the byte address shifted right by 2; PLL p's control register is at byte 0x400+4p, channel k (k = p*3 + c for channel c of PLL p) at byte 0x800+4k, and the lock-status word at byte 0x080.
- R6: A read of the lock-status word returns the lock input of PLL p in bit 8+p, with all other bits zero.
- R7: Writes to the lock-status address are ignored: no register changes and no strobe pulses.
- R8: An accepted write to PLL p's control register raises that PLL's strobe and the strobes of all channels of PLL p for exactly the following cycle.
- R9: An accepted write to a channel register raises only that channel's strobe, for exactly the following cycle.
- R10: Read data appears in the cycle after the read access and holds until the next read. A read of an unmapped address returns zero. A write to an unmapped address changes nothing.
- R11: The register outputs show the new value in the same cycle as the matching strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address in the window |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| pll_locked | input | 5 | Live lock state per PLL |
| bus_rdata | output | 32 | Registered read data |
| pll_ctrl_q | output | 160 | PLL control registers, PLL p at bits 32p+31:32p |
| chan_ctrl_q | output | 480 | Channel control registers, channel k at bits 32k+31:32k |
| pll_upd | output | 5 | Per-PLL update strobe |
| chan_upd | output | 15 | Per-channel update strobe |

## Verification
Some cases are hard to reach from the ports. One is an accepted PLL write in the cycle right after a channel write to another PLL, where the fan-out strobes of one must not merge into the single strobe of the other. Another is a bad-key write aimed at a register that already holds data, where a dropped write could still leak its low bits. The stimulus runs back-to-back writes with no idle cycle, and it hits filled registers with keys that differ from the correct one in one bit and in all bits. A behavioural model checks every strobe and register on every cycle, so a pulse that lasts one cycle too long or lands on the wrong unit is caught.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam logic [7:0] KEY_VALUE = 8'h5A;

  // Key check on the top byte of a write word.
  function automatic logic key_ok(input logic [31:0] w);
    return w[31:24] == KEY_VALUE;
  endfunction

  // Value kept in storage: key byte forced to zero.
  function automatic logic [31:0] key_strip(input logic [31:0] w);
    return {8'h00, w[23:0]};
  endfunction
endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec #(
  parameter int ADDR_W        = 13,
  parameter int NUM_PLL       = 5,
  parameter int NUM_CHAN      = 15,
  parameter int LOCK_IDX      = 32,
  parameter int PLL_BASE_IDX  = 256,
  parameter int CHAN_BASE_IDX = 512
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                aligned,
  output logic [NUM_PLL-1:0]  pll_hit,
  output logic [NUM_CHAN-1:0] chan_hit,
  output logic                lock_hit
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;

  assign idx      = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign lock_hit = aligned && (idx == IDX_W'(LOCK_IDX));

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    assign pll_hit[p] = aligned && (idx == IDX_W'(PLL_BASE_IDX + p));
  end
  for (genvar k = 0; k < NUM_CHAN; k++) begin : g_chan
    assign chan_hit[k] = aligned && (idx == IDX_W'(CHAN_BASE_IDX + k));
  end

  // R5: one address selects at most one register
  always_comb begin
    a_r5_single_hit: assert ($onehot0({pll_hit, chan_hit, lock_hit}));
  end
endmodule

// File: rtl/clkctl_reg_slot.sv
module clkctl_reg_slot (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] d,
  output logic [31:0] q,
  output logic        upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      upd <= 1'b0;
    end else begin
      upd <= we;
      if (we) q <= d;
    end
  end

  // R3: the stored key byte always reads zero
  a_r3_key_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    q[31:24] == 8'h00);
  // R11: without a write the register holds
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/clkctl_rd_mux.sv
module clkctl_rd_mux #(
  parameter int NUM_PLL  = 5,
  parameter int NUM_CHAN = 15,
  parameter int LOCK_LSB = 8
) (
  input  logic [NUM_PLL-1:0]     pll_hit,
  input  logic [NUM_CHAN-1:0]    chan_hit,
  input  logic                   lock_hit,
  input  logic [NUM_PLL*32-1:0]  pll_q,
  input  logic [NUM_CHAN*32-1:0] chan_q,
  input  logic [NUM_PLL-1:0]     locked,
  output logic [31:0]            rd_word
);
  logic [31:0] lock_word;

  always_comb begin
    lock_word = '0;
    for (int p = 0; p < NUM_PLL; p++) lock_word[LOCK_LSB + p] = locked[p];
  end

  always_comb begin
    rd_word = lock_hit ? lock_word : 32'h0;
    for (int p = 0; p < NUM_PLL; p++)
      if (pll_hit[p]) rd_word = rd_word | pll_q[p*32 +: 32];
    for (int k = 0; k < NUM_CHAN; k++)
      if (chan_hit[k]) rd_word = rd_word | chan_q[k*32 +: 32];
  end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile #(
  parameter int NUM_PLL       = 5,
  parameter int CHAN_PER_PLL  = 3,
  parameter int WIN_BYTES     = 8192,
  parameter int LOCK_IDX      = 32,
  parameter int LOCK_LSB      = 8,
  parameter int PLL_BASE_IDX  = 256,
  parameter int CHAN_BASE_IDX = 512
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_valid,
  input  logic                                bus_write,
  input  logic [$clog2(WIN_BYTES)-1:0]        bus_addr,
  input  logic [31:0]                         bus_wdata,
  input  logic [NUM_PLL-1:0]                  pll_locked,
  output logic [31:0]                         bus_rdata,
  output logic [NUM_PLL*32-1:0]               pll_ctrl_q,
  output logic [NUM_PLL*CHAN_PER_PLL*32-1:0]  chan_ctrl_q,
  output logic [NUM_PLL-1:0]                  pll_upd,
  output logic [NUM_PLL*CHAN_PER_PLL-1:0]     chan_upd
);
  import clkctl_pkg::*;

  localparam int ADDR_W   = $clog2(WIN_BYTES);
  localparam int NUM_CHAN = NUM_PLL * CHAN_PER_PLL;

  // Named internal events
  logic                aligned, lock_hit;
  logic [NUM_PLL-1:0]  pll_hit, pll_slot_upd;
  logic [NUM_CHAN-1:0] chan_hit, chan_slot_upd;
  logic                wr_accept, rd_access;
  logic [31:0]         wr_value, rd_word;

  assign wr_accept = bus_valid && bus_write && aligned && key_ok(bus_wdata);
  assign rd_access = bus_valid && !bus_write;
  assign wr_value  = key_strip(bus_wdata);

  clkctl_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .NUM_CHAN(NUM_CHAN),
    .LOCK_IDX(LOCK_IDX), .PLL_BASE_IDX(PLL_BASE_IDX), .CHAN_BASE_IDX(CHAN_BASE_IDX)
  ) u_dec (
    .addr(bus_addr), .aligned(aligned), .pll_hit(pll_hit),
    .chan_hit(chan_hit), .lock_hit(lock_hit)
  );

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll_slot
    clkctl_reg_slot u_slot (
      .clk(clk), .rst_n(rst_n), .we(wr_accept && pll_hit[p]), .d(wr_value),
      .q(pll_ctrl_q[p*32 +: 32]), .upd(pll_slot_upd[p])
    );
  end

  for (genvar k = 0; k < NUM_CHAN; k++) begin : g_chan_slot
    clkctl_reg_slot u_slot (
      .clk(clk), .rst_n(rst_n), .we(wr_accept && chan_hit[k]), .d(wr_value),
      .q(chan_ctrl_q[k*32 +: 32]), .upd(chan_slot_upd[k])
    );
    // A PLL register write also reloads every channel of that PLL
    assign chan_upd[k] = chan_slot_upd[k] | pll_slot_upd[k / CHAN_PER_PLL];
  end

  assign pll_upd = pll_slot_upd;

  clkctl_rd_mux #(.NUM_PLL(NUM_PLL), .NUM_CHAN(NUM_CHAN), .LOCK_LSB(LOCK_LSB)) u_rd (
    .pll_hit(pll_hit), .chan_hit(chan_hit), .lock_hit(lock_hit),
    .pll_q(pll_ctrl_q), .chan_q(chan_ctrl_q), .locked(pll_locked), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (rd_access) bus_rdata <= rd_word;
  end

  // R2: a write without the key pulses nothing
  a_r2_bad_key_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_wdata[31:24] != 8'h5A)
    |=> (pll_upd == '0 && chan_upd == '0));
  // R4: misaligned writes pulse nothing
  a_r4_misaligned_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[1:0] != 2'b00)
    |=> (pll_upd == '0 && chan_upd == '0));
  // R7: the lock address takes no write
  a_r7_lock_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(LOCK_IDX * 4))
    |=> (pll_upd == '0 && chan_upd == '0));
  // R6: lock read reflects the lock inputs of the access cycle
  a_r6_lock_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(LOCK_IDX * 4))
    |=> bus_rdata == (32'($past(pll_locked)) << LOCK_LSB));

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_fan_chk
    // R8: PLL write reloads the PLL and all of its channels
    a_r8_pll_fanout: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_wdata[31:24] == 8'h5A &&
       bus_addr == ADDR_W'((PLL_BASE_IDX + p) * 4))
      |=> (pll_upd[p] && (&chan_upd[p*CHAN_PER_PLL +: CHAN_PER_PLL])));
  end
endmodule

// File: tb/clkctl_regfile_tb_top.sv
`timescale 1ns/1ps
module clkctl_regfile_tb_top;
  localparam int NP = 5, CPP = 3, NC = NP * CPP;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [NP-1:0] pll_locked = '0;
  logic [31:0] bus_rdata;
  logic [NP*32-1:0] pll_ctrl_q;
  logic [NC*32-1:0] chan_ctrl_q;
  logic [NP-1:0] pll_upd;
  logic [NC-1:0] chan_upd;

  always #2.5 clk = ~clk;

  clkctl_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pll_locked(pll_locked),
    .bus_rdata(bus_rdata), .pll_ctrl_q(pll_ctrl_q), .chan_ctrl_q(chan_ctrl_q),
    .pll_upd(pll_upd), .chan_upd(chan_upd)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [31:0] m_pll [NP];
  logic [31:0] m_chan [NC];
  logic [31:0] m_rdata;
  logic [NP-1:0] m_pupd;
  logic [NC-1:0] m_cupd;
  int  idx;
  bit  al;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_pll[i] = 0;
      for (int i = 0; i < NC; i++) m_chan[i] = 0;
      m_rdata = 0; m_pupd = 0; m_cupd = 0;
    end else begin
      m_pupd = 0; m_cupd = 0;
      if (bus_valid) begin
        idx = int'(bus_addr) / 4;
        al  = (bus_addr % 4) == 0;
        if (bus_write) begin
          if (al && bus_wdata[31:24] == 8'h5A) begin
            if (idx >= 256 && idx < 256 + NP) begin
              m_pll[idx-256] = bus_wdata & 32'h00FF_FFFF;
              m_pupd[idx-256] = 1'b1;
              for (int c = 0; c < CPP; c++) m_cupd[(idx-256)*CPP + c] = 1'b1;
            end else if (idx >= 512 && idx < 512 + NC) begin
              m_chan[idx-512] = bus_wdata & 32'h00FF_FFFF;
              m_cupd[idx-512] = 1'b1;
            end
          end
        end else begin
          m_rdata = 0;
          if (al) begin
            if (idx == 32) for (int p = 0; p < NP; p++) m_rdata[8+p] = pll_locked[p];
            else if (idx >= 256 && idx < 256 + NP) m_rdata = m_pll[idx-256];
            else if (idx >= 512 && idx < 512 + NC) m_rdata = m_chan[idx-512];
          end
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      logic [NP*32-1:0] ep;
      logic [NC*32-1:0] ec;
      for (int i = 0; i < NP; i++) ep[i*32 +: 32] = m_pll[i];
      for (int i = 0; i < NC; i++) ec[i*32 +: 32] = m_chan[i];
      chk(cur_req, "rdata", 512'(bus_rdata), 512'(m_rdata));
      chk(cur_req, "pll regs", 512'(pll_ctrl_q), 512'(ep));
      chk(cur_req, "chan regs", 512'(chan_ctrl_q), 512'(ec));
      chk(cur_req, "pll strobe", 512'(pll_upd), 512'(m_pupd));
      chk(cur_req, "chan strobe", 512'(chan_upd), 512'(m_cupd));
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      summary();
    end
  end

  task automatic bus(bit v, bit w, logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
  endtask
  task automatic wr(logic [12:0] a, logic [31:0] d); bus(1, 1, a, d); endtask
  task automatic rd(logic [12:0] a);                 bus(1, 0, a, 0); endtask
  task automatic idle();                             bus(0, 0, 0, 0); endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(); idle();
    chk("R1", "reset rdata", 512'(bus_rdata), 512'(0));
    chk("R1", "reset strobes", 512'({pll_upd, chan_upd}), 512'(0));
    rst_n = 1'b1;
    rd(13'h400); idle();
    chk("R1", "pll0 after reset", 512'(bus_rdata), 512'(0));

    // R3 R8 R11: accepted PLL write
    cur_req = "R8";
    wr(13'h400, 32'h5A12_3456); idle();
    chk("R8", "pll0 strobe", 512'(pll_upd), 512'(5'b00001));
    chk("R8", "pll0 channel strobes", 512'(chan_upd), 512'(15'b000_0000_0000_0111));
    chk("R11", "pll0 value with strobe", 512'(pll_ctrl_q[31:0]), 512'(32'h0012_3456));
    idle();
    chk("R8", "strobe one cycle only", 512'({pll_upd, chan_upd}), 512'(0));
    cur_req = "R3";
    rd(13'h400); idle();
    chk("R3", "pll0 readback key cleared", 512'(bus_rdata), 512'(32'h0012_3456));

    // R2: wrong keys on a filled register
    cur_req = "R2";
    wr(13'h400, 32'h5BFF_FFFF); wr(13'h400, 32'hA5FF_FFFF); wr(13'h400, 32'h00AB_CDEF); idle();
    chk("R2", "pll0 unchanged", 512'(pll_ctrl_q[31:0]), 512'(32'h0012_3456));
    chk("R2", "no strobe", 512'({pll_upd, chan_upd}), 512'(0));

    // R9: channel write, single strobe
    cur_req = "R9";
    wr(13'h81C, 32'h5A00_0777); idle();
    chk("R9", "chan7 strobe only", 512'(chan_upd), 512'(15'h0080));
    chk("R9", "no pll strobe", 512'(pll_upd), 512'(0));

    // R4: misaligned access
    cur_req = "R4";
    wr(13'h401, 32'h5A99_9999); wr(13'h806, 32'h5A88_8888); rd(13'h403); idle();
    chk("R4", "misaligned read zero", 512'(bus_rdata), 512'(0));
    chk("R4", "pll0 kept", 512'(pll_ctrl_q[31:0]), 512'(32'h0012_3456));

    // R6 R7: lock status
    cur_req = "R7";
    wr(13'h080, 32'h5AFF_FFFF); idle();
    chk("R7", "lock write no strobe", 512'({pll_upd, chan_upd}), 512'(0));
    cur_req = "R6";
    pll_locked = 5'b10110;
    rd(13'h080); idle();
    chk("R6", "lock word", 512'(bus_rdata), 512'(32'h0000_1600));
    pll_locked = 5'b01001;
    rd(13'h080); idle();
    chk("R6", "lock word live", 512'(bus_rdata), 512'(32'h0000_0900));

    // R10: unmapped and hold
    cur_req = "R10";
    wr(13'h100, 32'h5A11_1111); rd(13'h100); idle();
    chk("R10", "unmapped read zero", 512'(bus_rdata), 512'(0));
    rd(13'h81C); idle(); idle();
    chk("R10", "rdata holds", 512'(bus_rdata), 512'(32'h0000_0777));

    // R5: edges of the map, back-to-back writes across units
    cur_req = "R5";
    wr(13'h410, 32'h5A44_4444); wr(13'h838, 32'h5AEE_EEEE); wr(13'h408, 32'h5A22_2222);
    wr(13'h820, 32'h5A88_0008); idle(); idle();
    rd(13'h410); idle();
    chk("R5", "last pll", 512'(bus_rdata), 512'(32'h0044_4444));
    rd(13'h838); idle();
    chk("R5", "last channel", 512'(bus_rdata), 512'(32'h00EE_EEEE));
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) wr(13'(13'h400 + 4 * (i % NP)), 32'h5A00_0000 | 32'(i * 4097));
      else if (i % 3 == 1) wr(13'(13'h800 + 4 * (i % NC)), 32'h5A00_0000 | 32'(i * 313));
      else rd(13'(13'h800 + 4 * (i % NC)));
    end
    idle(); idle();
    summary();
  end
endmodule